// File: doc/BRIEF.md
# Loop Stream Detector

This block sits beside a micro-op queue and watches every micro-op that is written into it. A taken branch whose target lies below its own address opens a candidate loop. The block then captures the following micro-ops as the loop body and, while it captures, tracks the figures that decide whether the loop may be streamed: how many micro-ops it holds, how many taken branches it contains, how many 32-byte code chunks it spans, whether every micro-op is also held in the micro-op cache, whether any call or return is present, and whether pushes and pops cancel out.

When the opening branch is seen taken again with the same target, the candidate is closed. If every rule holds, the block locks. It then streams the captured body from its own storage, one micro-op per cycle and wrapping without gaps. It also raises a sleep signal so that fetch and decode can power down. The stream continues until a branch mispredict or a pipeline flush arrives. A candidate that fails its rules is dropped, and the closing branch starts a fresh candidate in its place.

Top module: `uop_loop_streamer`

## Requirements
- R1: A loop locks only if its body, counted from the micro-op after the opening branch up to and including the closing branch, holds at most MAX_UOPS (default 28) micro-ops; 29 or more is rejected.
- R2: The body may hold at most MAX_TAKEN (default 8) taken branches, the closing branch included; one more is rejected.
- R3: The body may span at most MAX_CHUNKS (default 8) chunks. The first body micro-op always counts as one chunk, and every later body micro-op with `in_new_chunk` high counts one more.
- R4: A body in which any micro-op has `in_uc_resident` low is rejected.
- R5: A body containing any micro-op with `in_call` or `in_ret` high is rejected.
- R6: A body in which the number of micro-ops with `in_push` high differs from the number with `in_pop` high is rejected.
- R7: Only a taken branch with `in_target` < `in_pc` opens a candidate. The candidate closes on a taken branch with the same `in_pc` and `in_target` as the opener. On a qualifying close, `locked` and `sleep` rise after the next clock edge.
- R8: While locked, `out_valid` is high every cycle. `out_payload` gives body entries 0, 1, ... up to the last entry and then returns to entry 0, with no idle cycle.
- R9: While locked, input micro-ops are ignored: the replayed sequence is unchanged, even by micro-ops shaped like the closing branch or carrying a call.
- R10: On `mispredict` or `flush`, `sleep` and `out_valid` drop in the same cycle and `locked` is low after the next edge. A candidate being captured is discarded, so a new loop needs a fresh opening branch. After reset, all three outputs are low.
- R11: A rejected closing branch opens a new candidate in the same cycle. A taken backward branch that arrives after the candidate has already broken a rule also opens a new candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A micro-op is written to the queue this cycle |
| in_payload | input | PAY_W | Micro-op contents |
| in_pc | input | PC_W | Address of the instruction owning the micro-op |
| in_target | input | PC_W | Branch target, meaningful when taken |
| in_taken | input | 1 | Micro-op is a taken branch |
| in_call | input | 1 | Micro-op belongs to a call |
| in_ret | input | 1 | Micro-op belongs to a return |
| in_push | input | 1 | Micro-op pushes to the stack |
| in_pop | input | 1 | Micro-op pops from the stack |
| in_new_chunk | input | 1 | Micro-op begins a new 32-byte chunk |
| in_uc_resident | input | 1 | Micro-op is also held in the micro-op cache |
| mispredict | input | 1 | Branch mispredict reported |
| flush | input | 1 | Pipeline flush |
| out_valid | output | 1 | Replayed micro-op valid |
| out_payload | output | PAY_W | Replayed micro-op contents |
| sleep | output | 1 | Front end may sleep |
| locked | output | 1 | Loop is locked and streaming |

## Verification
`locked`, `sleep` and the first replayed entry appear one edge after the closing branch is presented. Each later entry follows exactly one edge after the previous one. A mispredict or flush clears `sleep` and `out_valid` combinationally in the cycle it is driven, and `locked` falls one edge later. The bench drives inputs on the falling edge and samples 1 ns after it, so every check lands in the cycle its requirement names. Expected lock decisions and replay sequences come from a bench function that applies the rules to the micro-ops it sent.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
package lsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_LOCKED  = 2'd2
    } lsd_state_e;

    typedef struct packed {
        logic taken;
        logic call;
        logic ret;
        logic push;
        logic pop;
        logic new_chunk;
        logic resident;
    } uop_flags_t;

    // increment with a ceiling, used by all saturating counters
    function automatic int unsigned sat_inc(input int unsigned v, input logic inc,
                                            input int unsigned cap);
        if (inc && (v < cap)) return v + 1;
        return v;
    endfunction

endpackage

// File: rtl/lsd_qual_tracker.sv
`timescale 1ns/1ps
module lsd_qual_tracker
    import lsd_pkg::*;
#(
    parameter int MAX_UOPS   = 28,
    parameter int MAX_TAKEN  = 8,
    parameter int MAX_CHUNKS = 8,
    localparam int CNT_W = $clog2(MAX_UOPS + 2),
    localparam int TK_W  = $clog2(MAX_TAKEN + 2),
    localparam int CH_W  = $clog2(MAX_CHUNKS + 2),
    localparam int BAL_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  uop_flags_t       flags,
    output logic [CNT_W-1:0] uop_cnt,
    output logic             ok_with,
    output logic             fail_now
);

    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic [TK_W-1:0]         tk_q, tk_d;
    logic [CH_W-1:0]         ch_q, ch_d;
    logic signed [BAL_W-1:0] bal_q, bal_d;
    logic                    bad_q, bad_d;
    logic                    frozen;

    // next values with the presented micro-op folded in
    always_comb begin
        cnt_d = CNT_W'(sat_inc(32'(cnt_q), 1'b1, MAX_UOPS + 1));
        tk_d  = TK_W'(sat_inc(32'(tk_q), flags.taken, MAX_TAKEN + 1));
        ch_d  = CH_W'(sat_inc(32'(ch_q), flags.new_chunk || (cnt_q == '0), MAX_CHUNKS + 1));
        bal_d = bal_q;
        if (flags.push) bal_d = bal_d + BAL_W'(1);
        if (flags.pop)  bal_d = bal_d - BAL_W'(1);
        bad_d = bad_q | flags.call | flags.ret | ~flags.resident;
    end

    assign ok_with  = !bad_d
                   && (int'(cnt_d) <= MAX_UOPS)
                   && (int'(tk_d)  <= MAX_TAKEN)
                   && (int'(ch_d)  <= MAX_CHUNKS)
                   && (bal_d == '0);

    assign frozen   = int'(cnt_q) > MAX_UOPS;

    assign fail_now = bad_q || frozen
                   || (int'(tk_q) > MAX_TAKEN)
                   || (int'(ch_q) > MAX_CHUNKS);

    assign uop_cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            tk_q  <= '0;
            ch_q  <= '0;
            bal_q <= '0;
            bad_q <= 1'b0;
        end else if (upd && !frozen) begin
            cnt_q <= cnt_d;
            tk_q  <= tk_d;
            ch_q  <= ch_d;
            bal_q <= bal_d;
            bad_q <= bad_d;
        end
    end

endmodule

// File: rtl/lsd_loop_buf.sv
`timescale 1ns/1ps
module lsd_loop_buf #(
    parameter int PAY_W = 16,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [PAY_W-1:0] wdata,
    input  logic             start,
    input  logic             adv,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] rd_ptr,
    output logic [PAY_W-1:0] rd_data
);

    logic [PAY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read pointer steps every cycle and folds back at the loop end
    always_ff @(posedge clk) begin
        if (rst || start) begin
            rd_ptr <= '0;
        end else if (adv) begin
            rd_ptr <= (rd_ptr == last_idx) ? '0 : rd_ptr + IDX_W'(1);
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/uop_loop_streamer.sv
`timescale 1ns/1ps
module uop_loop_streamer
    import lsd_pkg::*;
#(
    parameter int PAY_W      = 16,
    parameter int PC_W       = 16,
    parameter int DEPTH      = 32,
    parameter int MAX_UOPS   = 28,
    parameter int MAX_TAKEN  = 8,
    parameter int MAX_CHUNKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PAY_W-1:0] in_payload,
    input  logic [PC_W-1:0]  in_pc,
    input  logic [PC_W-1:0]  in_target,
    input  logic             in_taken,
    input  logic             in_call,
    input  logic             in_ret,
    input  logic             in_push,
    input  logic             in_pop,
    input  logic             in_new_chunk,
    input  logic             in_uc_resident,
    input  logic             mispredict,
    input  logic             flush,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_payload,
    output logic             sleep,
    output logic             locked
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(MAX_UOPS + 2);

    lsd_state_e       state_q;
    logic [PC_W-1:0]  cand_pc_q, cand_tgt_q;
    logic [IDX_W-1:0] last_idx, rd_ptr;
    logic [CNT_W-1:0] uop_cnt;
    uop_flags_t       flags;
    logic evt, acc, capturing, is_bwd, closing;
    logic ok_with, fail_now, open_new, lock_go, buf_we;

    assign flags = '{taken: in_taken, call: in_call, ret: in_ret, push: in_push,
                     pop: in_pop, new_chunk: in_new_chunk, resident: in_uc_resident};

    assign evt       = mispredict | flush;
    assign acc       = in_valid && !evt && (state_q != ST_LOCKED);
    assign capturing = acc && (state_q == ST_CAPTURE);
    assign is_bwd    = in_taken && (in_target < in_pc);
    assign closing   = in_taken && (in_pc == cand_pc_q) && (in_target == cand_tgt_q);

    assign lock_go  = capturing && closing && ok_with;
    assign open_new = (acc && (state_q == ST_IDLE) && is_bwd)
                   || (capturing && closing && !ok_with)
                   || (capturing && !closing && is_bwd && fail_now);
    assign buf_we   = capturing && (int'(uop_cnt) < DEPTH);

    lsd_qual_tracker #(
        .MAX_UOPS  (MAX_UOPS),
        .MAX_TAKEN (MAX_TAKEN),
        .MAX_CHUNKS(MAX_CHUNKS)
    ) u_track (
        .clk     (clk),
        .rst     (rst),
        .clr     (evt | open_new | lock_go),
        .upd     (capturing),
        .flags   (flags),
        .uop_cnt (uop_cnt),
        .ok_with (ok_with),
        .fail_now(fail_now)
    );

    lsd_loop_buf #(
        .PAY_W(PAY_W),
        .DEPTH(DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .we      (buf_we),
        .waddr   (IDX_W'(uop_cnt)),
        .wdata   (in_payload),
        .start   (lock_go),
        .adv     ((state_q == ST_LOCKED) && !evt),
        .last_idx(last_idx),
        .rd_ptr  (rd_ptr),
        .rd_data (out_payload)
    );

    always_ff @(posedge clk) begin
        if (rst || evt) begin
            state_q    <= ST_IDLE;
            cand_pc_q  <= '0;
            cand_tgt_q <= '0;
            last_idx   <= '0;
        end else if (lock_go) begin
            state_q  <= ST_LOCKED;
            last_idx <= IDX_W'(uop_cnt);
        end else if (open_new) begin
            state_q    <= ST_CAPTURE;
            cand_pc_q  <= in_pc;
            cand_tgt_q <= in_target;
        end
    end

    assign locked    = (state_q == ST_LOCKED);
    assign sleep     = locked && !evt;
    assign out_valid = locked && !evt;

endmodule

// File: rtl/lsd_checker.sv
`timescale 1ns/1ps
module lsd_checker #(
    parameter int IDX_W    = 5,
    parameter int MAX_UOPS = 28
) (
    input logic             clk,
    input logic             rst,
    input logic             mispredict,
    input logic             flush,
    input logic             sleep,
    input logic             out_valid,
    input logic             locked,
    input logic             buf_we,
    input logic [IDX_W-1:0] rd_ptr,
    input logic [IDX_W-1:0] last_idx
);

    p_evt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mispredict || flush) |-> (!sleep && !out_valid));

    p_evt_unlock_r10: assert property (@(posedge clk) disable iff (rst)
        (mispredict || flush) |=> !locked);

    p_hold_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && !mispredict && !flush) |=> locked);

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && !mispredict && !flush && rd_ptr == last_idx) |=> (rd_ptr == '0));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && !mispredict && !flush && rd_ptr != last_idx)
        |=> (rd_ptr == IDX_W'($past(rd_ptr) + 1'b1)));

    p_no_capture_r9: assert property (@(posedge clk) disable iff (rst)
        locked |-> !buf_we);

    p_len_bound_r1: assert property (@(posedge clk) disable iff (rst)
        locked |-> (int'(last_idx) < MAX_UOPS));

endmodule

bind uop_loop_streamer lsd_checker #(
    .IDX_W   (IDX_W),
    .MAX_UOPS(MAX_UOPS)
) u_lsd_chk (
    .clk       (clk),
    .rst       (rst),
    .mispredict(mispredict),
    .flush     (flush),
    .sleep     (sleep),
    .out_valid (out_valid),
    .locked    (locked),
    .buf_we    (buf_we),
    .rd_ptr    (rd_ptr),
    .last_idx  (last_idx)
);

// File: tb/uop_loop_streamer_tb.sv
`timescale 1ns/1ps
module uop_loop_streamer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_payload = '0, in_pc = '0, in_target = '0;
    logic        in_taken = 1'b0, in_call = 1'b0, in_ret = 1'b0, in_push = 1'b0;
    logic        in_pop = 1'b0, in_new_chunk = 1'b0, in_uc_resident = 1'b0;
    logic        mispredict = 1'b0, flush = 1'b0;
    logic        out_valid, sleep, locked;
    logic [15:0] out_payload;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    bit [15:0] pay [64];
    bit [15:0] bpc [64];
    bit [15:0] btg [64];
    bit tk [64], cl [64], rt [64], ps [64], pp [64], ch [64], rs [64];

    always #4 clk = ~clk;

    uop_loop_streamer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_payload(in_payload),
        .in_pc(in_pc), .in_target(in_target), .in_taken(in_taken),
        .in_call(in_call), .in_ret(in_ret), .in_push(in_push), .in_pop(in_pop),
        .in_new_chunk(in_new_chunk), .in_uc_resident(in_uc_resident),
        .mispredict(mispredict), .flush(flush), .out_valid(out_valid),
        .out_payload(out_payload), .sleep(sleep), .locked(locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic make_clean(input int base, input int n);
        for (int i = base; i < base + n; i++) begin
            pay[i] = 16'($urandom);
            bpc[i] = 16'(10 + i);
            btg[i] = '0;
            tk[i] = 0; cl[i] = 0; rt[i] = 0; ps[i] = 0; pp[i] = 0; ch[i] = 0; rs[i] = 1;
        end
        bpc[base+n-1] = 16'd100;
        btg[base+n-1] = 16'd10;
        tk[base+n-1]  = 1;
    endtask

    function automatic bit expect_ok(input int base, input int n);
        int t = 0, c = 1, b = 0;
        bit bad = 0;
        for (int i = base; i < base + n; i++) begin
            t += tk[i];
            if (i > base) c += ch[i];
            b += ps[i];
            b -= pp[i];
            if (cl[i] || rt[i] || !rs[i]) bad = 1;
        end
        return (n <= 28) && (t <= 8) && (c <= 8) && (b == 0) && !bad;
    endfunction

    task automatic drive_idx(input int i);
        @(negedge clk);
        in_valid = 1; in_payload = pay[i]; in_pc = bpc[i]; in_target = btg[i];
        in_taken = tk[i]; in_call = cl[i]; in_ret = rt[i]; in_push = ps[i];
        in_pop = pp[i]; in_new_chunk = ch[i]; in_uc_resident = rs[i];
    endtask

    task automatic drive_open(input bit [15:0] pc, input bit [15:0] tgt);
        @(negedge clk);
        in_valid = 1; in_payload = 16'($urandom); in_pc = pc; in_target = tgt;
        in_taken = 1; in_call = 0; in_ret = 0; in_push = 0; in_pop = 0;
        in_new_chunk = 0; in_uc_resident = 1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 0; in_taken = 0;
        #1;
    endtask

    task automatic check_replay(input int base, input int n, input int cycles, input string tag);
        for (int k = 0; k < cycles; k++) begin
            if (k > 0) begin @(negedge clk); #1; end
            chk(out_valid && sleep && (out_payload == pay[base + (k % n)]), tag,
                int'(out_payload), int'(pay[base + (k % n)]));
        end
    endtask

    task automatic pulse_evt(input bit use_flush, input bit was_locked);
        @(negedge clk);
        in_valid = 0; in_taken = 0;
        mispredict = !use_flush; flush = use_flush;
        #1;
        if (was_locked) chk(!sleep && !out_valid, "R10 same-cycle drop", int'(sleep), 0);
        @(negedge clk);
        mispredict = 0; flush = 0;
        #1;
        chk(!locked, "R10 unlocked", int'(locked), 0);
    endtask

    task automatic run_std(input int n, input string tag);
        bit e;
        drive_open(16'd100, 16'd10);
        for (int i = 0; i < n; i++) drive_idx(i);
        go_idle();
        e = expect_ok(0, n);
        chk(locked == e, tag, int'(locked), int'(e));
        if (e) check_replay(0, n, 2 * n + 2, "R8 replay order");
        pulse_evt(0, e);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(!locked && !sleep && !out_valid, "R10 reset state", int'(locked), 0);

        // R1: size limit
        make_clean(0, 28); run_std(28, "R1 28 uops lock");
        make_clean(0, 29); run_std(29, "R1 29 uops reject");

        // R2: taken branch limit (closing branch included)
        make_clean(0, 12);
        for (int i = 1; i <= 7; i++) begin tk[i] = 1; btg[i] = bpc[i] + 5; end
        run_std(12, "R2 8 taken lock");
        tk[9] = 1; btg[9] = bpc[9] + 5;
        run_std(12, "R2 9 taken reject");

        // R3: chunk limit, first entry always one chunk
        make_clean(0, 10);
        ch[0] = 1;
        for (int i = 1; i <= 7; i++) ch[i] = 1;
        run_std(10, "R3 8 chunks lock");
        ch[8] = 1;
        run_std(10, "R3 9 chunks reject");

        // R4: residency
        make_clean(0, 6); rs[3] = 0; run_std(6, "R4 non-resident reject");

        // R5: call / return
        make_clean(0, 6); cl[2] = 1; run_std(6, "R5 call reject");
        make_clean(0, 6); rt[4] = 1; run_std(6, "R5 return reject");

        // R6: stack balance
        make_clean(0, 8); ps[1] = 1; ps[2] = 1; pp[5] = 1; pp[6] = 1;
        run_std(8, "R6 balanced lock");
        pp[6] = 0; run_std(8, "R6 unbalanced reject");

        // R7: same pc different target is an inner branch, not a close
        make_clean(0, 4); bpc[1] = 16'd100; btg[1] = 16'd11; tk[1] = 1;
        run_std(4, "R7 close needs same target");
        // R7: forward taken branch does not open
        make_clean(0, 3);
        drive_open(16'd100, 16'd200);
        for (int i = 0; i < 3; i++) drive_idx(i);
        go_idle();
        chk(!locked, "R7 forward opener ignored", int'(locked), 0);
        pulse_evt(0, 0);

        // R9: input ignored while locked
        make_clean(0, 6);
        drive_open(16'd100, 16'd10);
        for (int i = 0; i < 6; i++) drive_idx(i);
        go_idle();
        chk(locked, "R9 setup lock", int'(locked), 1);
        for (int k = 0; k < 14; k++) begin
            if (k > 0) begin
                @(negedge clk);
                in_valid = 1; in_payload = 16'hdead; in_pc = 16'd100; in_target = 16'd10;
                in_taken = 1; in_call = k[0]; in_uc_resident = 1;
                #1;
            end
            chk(out_valid && out_payload == pay[k % 6], "R9 replay unchanged",
                int'(out_payload), int'(pay[k % 6]));
        end
        in_call = 0;
        pulse_evt(1, 1);

        // R10: flush mid-capture discards candidate
        make_clean(0, 4);
        drive_open(16'd100, 16'd10);
        drive_idx(0); drive_idx(1);
        @(negedge clk); in_valid = 0; flush = 1;
        @(negedge clk); flush = 0;
        drive_idx(2); drive_idx(3);
        go_idle();
        chk(!locked, "R10 capture discarded", int'(locked), 0);
        for (int i = 0; i < 4; i++) drive_idx(i);
        go_idle();
        chk(locked, "R10 fresh opener locks", int'(locked), 1);
        check_replay(0, 4, 9, "R8 replay after reopen");
        pulse_evt(0, 1);

        // R11: rejected close reopens with the same branch
        make_clean(0, 5); cl[2] = 1;
        drive_open(16'd100, 16'd10);
        for (int i = 0; i < 5; i++) drive_idx(i);
        go_idle();
        chk(!locked, "R11 first pass rejected", int'(locked), 0);
        make_clean(0, 5);
        for (int i = 0; i < 5; i++) drive_idx(i);
        go_idle();
        chk(locked, "R11 second pass locks", int'(locked), 1);
        check_replay(0, 5, 11, "R11 replay");
        pulse_evt(0, 1);

        // R11: failed candidate reopens on another backward branch
        make_clean(0, 29); tk[28] = 0; bpc[28] = 16'd38; btg[28] = '0;
        bpc[29] = 16'd200; btg[29] = 16'd50; tk[29] = 1; pay[29] = 16'h1111;
        cl[29] = 0; rt[29] = 0; ps[29] = 0; pp[29] = 0; ch[29] = 0; rs[29] = 1;
        make_clean(30, 4); bpc[33] = 16'd200; btg[33] = 16'd50;
        drive_open(16'd100, 16'd10);
        for (int i = 0; i < 34; i++) drive_idx(i);
        go_idle();
        chk(locked, "R11 reopen on new branch", int'(locked), 1);
        check_replay(30, 4, 10, "R11 reopened replay");
        pulse_evt(0, 1);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int n;
            n = 1 + int'($urandom % 32);
            make_clean(0, n);
            for (int i = 0; i < n; i++) begin
                cl[i] = ($urandom % 40) == 0;
                rt[i] = ($urandom % 40) == 0;
                rs[i] = ($urandom % 40) != 0;
                ps[i] = ($urandom % 6) == 0;
                pp[i] = ($urandom % 6) == 0;
                ch[i] = ($urandom % 4) == 0;
                if (i < n - 1 && ($urandom % 6) == 0) begin
                    tk[i] = 1; btg[i] = bpc[i] + 5;
                end
            end
            run_std(n, "R1-mix random lock decision");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule